// File: doc/BRIEF.md
# Serial wire debug host engine

This block is the host side of a two-wire serial debug link. It generates the debug clock from the system clock through a programmable divider and drives a shared, bidirectional data line. The line is presented as three signals: output value, output enable and input. A single request names the port group (access port or debug port), the direction, a two-bit register index and a write word. The engine then runs one complete packet. It sends an eight-bit header, releases the line for turnaround and reads back a three-bit acknowledge. It then moves a data word and its parity bit in the direction the request asked for.

When the packet ends, the engine returns the read word, the acknowledge code, a parity-error flag and a flag that asks the surrounding logic for a line reset. On WAIT or FAULT the data phase is skipped. On any other unexpected acknowledge, the engine keeps its driver off the line for as long as a data phase would last before it reports. Accepted packets that end normally are followed by a fixed number of idle clocks with the line held low. Retrying and chaining packets are left to the logic that issues the requests.

Top module: `swd_host_engine`

## Requirements
- R1: After reset the debug clock is low, the data line is not driven (`swdio_oe`=0), `req_ready` is 1 and `rsp_valid` is 0.
- R2: The header is sent in this bit order: start 1, port select (1 = access port), read flag (1 = read), address bit 2 (`req_addr[0]`), address bit 3 (`req_addr[1]`), parity, stop 0, park 1. The parity bit makes the number of ones over the port select, read flag, both address bits and the parity bit itself even. Written as a byte whose MSB is the first bit on the wire, a debug-port read of register 0 is 0xA5, a debug-port write with `req_addr`=2 is 0x8D, and an access-port read with `req_addr`=3 is 0xF9.
- R3: The debug clock idles low and toggles only during a packet. Each half period lasts `div_half`+1 system clocks. The driven value and enable change only in the cycle in which the debug clock falls. The data line is sampled in the cycle in which the clock rises.
- R4: Exactly one undriven bit period follows the header. On a write that receives OK, one more undriven bit period follows the acknowledge, before the data. The host never drives while the target drives.
- R5: The three acknowledge bits are received with the first bit in bit 0 of `rsp_ack`. 001 is OK, 010 is WAIT and 100 is FAULT.
- R6: A read with OK receives 32 data bits LSB first and then one parity bit, followed by one undriven bit. The word appears on `rsp_rdata`. `rsp_par_err` is 1 exactly when the received parity bit differs from the odd-ones rule of R7.
- R7: A write with OK drives 32 data bits LSB first and then a parity bit, which is 1 when the word holds an odd number of ones.
- R8: On WAIT or FAULT the packet has no data phase. One undriven bit follows the acknowledge, then the idle clocks. `rsp_rdata` and `rsp_par_err` are 0.
- R9: On any other acknowledge code, the line stays undriven for 34 bit periods after the acknowledge (turnaround plus a full data phase). No idle clocks follow. `rsp_line_reset` is 1 and the line is left undriven afterwards.
- R10: After a packet that ends in OK, WAIT or FAULT, the engine runs `IDLE_CYCLES` clocks with the line driven low. The line then stays driven low until the next request.
- R11: `rsp_valid` is a one-cycle pulse. It arrives exactly 2·B·(`div_half`+1) system clocks after the accepting clock edge. B is the packet's bit count: 48 for OK reads and writes, 15 for WAIT or FAULT (with `IDLE_CYCLES`=2), and 46 for protocol errors.
- R12: `req_ready` is 0 during a packet. A `req_valid` raised then has no effect on the running packet and starts no further packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_half | input | DIV_W | Debug clock half period minus one, in system clocks |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_ap | input | 1 | 1 selects the access port, 0 the debug port |
| req_rnw | input | 1 | 1 for read, 0 for write |
| req_addr | input | 2 | Register address bits 3:2 |
| req_wdata | input | DATA_W | Word to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_ack | output | 3 | Received acknowledge, first bit in bit 0 |
| rsp_rdata | output | DATA_W | Read word (0 unless an OK read) |
| rsp_par_err | output | 1 | Read parity mismatch |
| rsp_line_reset | output | 1 | Unexpected acknowledge; line reset needed |
| swclk | output | 1 | Debug clock |
| swdio_o | output | 1 | Data line drive value |
| swdio_oe | output | 1 | Data line drive enable |
| swdio_i | input | 1 | Data line sampled value |

## Verification
Each result is due after a known number of system clocks. The bench records the host's drive on every rising debug-clock edge as bit n of the packet, and a target model answers on those same edges. It therefore checks headers, turnarounds, data and idle bits by bit index rather than by time. Completion is checked by counting falling system-clock edges from the accept edge to the first one where `rsp_valid` is high, and comparing the count with 2·B·(`div_half`+1). The half-period length is measured directly between debug-clock edges. All outputs are sampled on falling system-clock edges, half a period away from where they change.

// File: rtl/swd_pkg.sv
package swd_pkg;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR,
    ST_TRN_A,
    ST_ACK,
    ST_TRN_W,
    ST_WDATA,
    ST_RDATA,
    ST_TRN_B,
    ST_BACKOFF,
    ST_TAIL
  } swd_state_e;

  // Header as shifted out, bit 0 leaves first.
  function automatic logic [7:0] hdr_lsb_first(input logic ap, input logic rnw,
                                               input logic [1:0] a);
    logic p;
    p = ap ^ rnw ^ a[0] ^ a[1];
    return {1'b1, 1'b0, p, a[1], a[0], rnw, ap, 1'b1};
  endfunction

  function automatic logic ack_is_known(input logic [2:0] a);
    return (a == ACK_OK) || (a == ACK_WAIT) || (a == ACK_FAULT);
  endfunction

endpackage

// File: rtl/swd_tick_gen.sv
module swd_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_half,
  output logic             swclk,
  output logic             rise_stb,
  output logic             fall_stb
);

  logic [DIV_W-1:0] cnt_q;
  logic             clk_q;
  logic             hit;

  assign hit      = run && (cnt_q == div_half);
  assign rise_stb = hit && !clk_q;
  assign fall_stb = hit && clk_q;
  assign swclk    = clk_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (hit) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/swd_link_fsm.sv
module swd_link_fsm
  import swd_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int IDLE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_stb,
  input  logic              fall_stb,
  output logic              run,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_ap,
  input  logic              req_rnw,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [2:0]        rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_par_err,
  output logic              rsp_line_reset,
  input  logic              swdio_i,
  output logic              swdio_o,
  output logic              swdio_oe
);

  localparam int BACKOFF_BITS = DATA_W + 2;
  localparam int MAX_BITS     = (BACKOFF_BITS > IDLE_CYCLES) ? BACKOFF_BITS : IDLE_CYCLES;
  localparam int CNT_W        = $clog2(MAX_BITS + 1);

  swd_state_e        state_q;
  logic [CNT_W-1:0]  bit_q;
  logic [CNT_W-1:0]  last_idx;
  logic [7:0]        hdr_sr;
  logic [DATA_W:0]   tx_sr;
  logic [DATA_W:0]   rx_sr;
  logic [2:0]        ack_sr;
  logic [2:0]        ack_q;
  logic              rnw_q;
  logic              rd_ok;

  assign run       = (state_q != ST_IDLE);
  assign req_ready = (state_q == ST_IDLE);
  assign rd_ok     = rnw_q && (ack_q == ACK_OK);

  always_comb begin
    case (state_q)
      ST_HDR:            last_idx = CNT_W'(7);
      ST_ACK:            last_idx = CNT_W'(2);
      ST_WDATA,
      ST_RDATA:          last_idx = CNT_W'(DATA_W);
      ST_BACKOFF:        last_idx = CNT_W'(BACKOFF_BITS - 1);
      ST_TAIL:           last_idx = CNT_W'(IDLE_CYCLES - 1);
      default:           last_idx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_IDLE;
      bit_q          <= '0;
      hdr_sr         <= '0;
      tx_sr          <= '0;
      rx_sr          <= '0;
      ack_sr         <= '0;
      ack_q          <= '0;
      rnw_q          <= 1'b0;
      swdio_o        <= 1'b0;
      swdio_oe       <= 1'b0;
      rsp_valid      <= 1'b0;
      rsp_ack        <= '0;
      rsp_rdata      <= '0;
      rsp_par_err    <= 1'b0;
      rsp_line_reset <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (req_valid) begin
          hdr_sr   <= hdr_lsb_first(req_ap, req_rnw, req_addr);
          tx_sr    <= {^req_wdata, req_wdata};
          rnw_q    <= req_rnw;
          bit_q    <= '0;
          swdio_o  <= 1'b1;
          swdio_oe <= 1'b1;
          state_q  <= ST_HDR;
        end
      end else begin
        // sample on the system edge where the debug clock rises
        if (rise_stb) begin
          if (state_q == ST_ACK)   ack_sr <= {swdio_i, ack_sr[2:1]};
          if (state_q == ST_RDATA) rx_sr  <= {swdio_i, rx_sr[DATA_W:1]};
        end
        // advance one bit on the edge where the debug clock falls
        if (fall_stb) begin
          if (bit_q != last_idx) begin
            bit_q <= bit_q + CNT_W'(1);
            if (state_q == ST_HDR) begin
              hdr_sr  <= hdr_sr >> 1;
              swdio_o <= hdr_sr[1];
            end
            if (state_q == ST_WDATA) begin
              tx_sr   <= tx_sr >> 1;
              swdio_o <= tx_sr[1];
            end
          end else begin
            bit_q <= '0;
            case (state_q)
              ST_HDR: begin
                swdio_oe <= 1'b0;
                state_q  <= ST_TRN_A;
              end
              ST_TRN_A: state_q <= ST_ACK;
              ST_ACK: begin
                ack_q <= ack_sr;
                if (ack_sr == ACK_OK) begin
                  state_q <= rnw_q ? ST_RDATA : ST_TRN_W;
                end else if (ack_is_known(ack_sr)) begin
                  state_q <= ST_TRN_B;
                end else begin
                  state_q <= ST_BACKOFF;
                end
              end
              ST_TRN_W: begin
                swdio_oe <= 1'b1;
                swdio_o  <= tx_sr[0];
                state_q  <= ST_WDATA;
              end
              ST_RDATA: state_q <= ST_TRN_B;
              ST_WDATA,
              ST_TRN_B: begin
                swdio_oe <= 1'b1;
                swdio_o  <= 1'b0;
                state_q  <= ST_TAIL;
              end
              ST_TAIL: begin
                rsp_valid      <= 1'b1;
                rsp_ack        <= ack_q;
                rsp_rdata      <= rd_ok ? rx_sr[DATA_W-1:0] : '0;
                rsp_par_err    <= rd_ok && (^rx_sr);
                rsp_line_reset <= 1'b0;
                state_q        <= ST_IDLE;
              end
              ST_BACKOFF: begin
                rsp_valid      <= 1'b1;
                rsp_ack        <= ack_q;
                rsp_rdata      <= '0;
                rsp_par_err    <= 1'b0;
                rsp_line_reset <= 1'b1;
                state_q        <= ST_IDLE;
              end
              default: state_q <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end

endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine #(
  parameter int DATA_W      = 32,
  parameter int DIV_W       = 8,
  parameter int IDLE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div_half,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_ap,
  input  logic              req_rnw,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [2:0]        rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_par_err,
  output logic              rsp_line_reset,
  output logic              swclk,
  output logic              swdio_o,
  output logic              swdio_oe,
  input  logic              swdio_i
);

  logic run;
  logic rise_stb;
  logic fall_stb;

  swd_tick_gen #(
    .DIV_W(DIV_W)
  ) u_tick (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .div_half(div_half),
    .swclk   (swclk),
    .rise_stb(rise_stb),
    .fall_stb(fall_stb)
  );

  swd_link_fsm #(
    .DATA_W     (DATA_W),
    .IDLE_CYCLES(IDLE_CYCLES)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .rise_stb      (rise_stb),
    .fall_stb      (fall_stb),
    .run           (run),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_ap        (req_ap),
    .req_rnw       (req_rnw),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .rsp_valid     (rsp_valid),
    .rsp_ack       (rsp_ack),
    .rsp_rdata     (rsp_rdata),
    .rsp_par_err   (rsp_par_err),
    .rsp_line_reset(rsp_line_reset),
    .swdio_i       (swdio_i),
    .swdio_o       (swdio_o),
    .swdio_oe      (swdio_oe)
  );

endmodule

// File: rtl/swd_host_chk.sv
module swd_host_chk (
  input logic       clk,
  input logic       rst,
  input logic       swclk,
  input logic       swdio_o,
  input logic       swdio_oe,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic [2:0] rsp_ack,
  input logic       rsp_par_err,
  input logic       rsp_line_reset
);

  AST_ACCEPT_STARTS_HDR: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (swdio_oe && swdio_o && !swclk && !req_ready)); // R2

  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !swclk); // R3

  AST_DRIVE_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst)
    swclk |-> ($stable(swdio_o) && $stable(swdio_oe))); // R3

  AST_PARERR_NEEDS_OK: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_par_err) |-> (rsp_ack == 3'b001)); // R6

  AST_LINE_RESET_CODE: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_line_reset) |->
      (rsp_ack != 3'b001 && rsp_ack != 3'b010 && rsp_ack != 3'b100 && !swdio_oe)); // R9

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R11

  AST_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (req_ready && !swclk)); // R11

endmodule

bind swd_host_engine swd_host_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .swclk         (swclk),
  .swdio_o       (swdio_o),
  .swdio_oe      (swdio_oe),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ack       (rsp_ack),
  .rsp_par_err   (rsp_par_err),
  .rsp_line_reset(rsp_line_reset)
);

// File: tb/swd_host_engine_tb.sv
module swd_host_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int IDLE_N     = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  div_half = 8'd1;
  logic        req_valid = 1'b0;
  logic        req_ap = 1'b0;
  logic        req_rnw = 1'b0;
  logic [1:0]  req_addr = 2'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        req_ready;
  logic        rsp_valid;
  logic [2:0]  rsp_ack;
  logic [31:0] rsp_rdata;
  logic        rsp_par_err;
  logic        rsp_line_reset;
  logic        swclk;
  logic        swdio_o;
  logic        swdio_oe;
  logic        swdio_i;

  // target model state
  logic        tgt_oe = 1'b0;
  logic        tgt_o = 1'b0;
  logic [2:0]  tgt_ack = 3'b001;
  logic [31:0] tgt_rdata = 32'd0;
  logic        tgt_flip = 1'b0;
  logic        rnw_seen = 1'b0;
  int          pkt_id = 0;
  int          seen_id = -1;
  int          nbits = 0;
  logic        cap_oe [0:127];
  logic        cap_v  [0:127];

  int checks = 0;
  int errors = 0;
  int clash  = 0;
  bit done   = 1'b0;

  assign swdio_i = tgt_oe ? tgt_o : (swdio_oe ? swdio_o : 1'b1);

  swd_host_engine #(
    .DATA_W(32), .DIV_W(8), .IDLE_CYCLES(IDLE_N)
  ) u_dut (
    .clk(clk), .rst(rst), .div_half(div_half),
    .req_valid(req_valid), .req_ready(req_ready), .req_ap(req_ap),
    .req_rnw(req_rnw), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
    .rsp_par_err(rsp_par_err), .rsp_line_reset(rsp_line_reset),
    .swclk(swclk), .swdio_o(swdio_o), .swdio_oe(swdio_oe), .swdio_i(swdio_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Target: records host bit n at its rising edge, sets its drive for bit n+1.
  always @(posedge swclk) begin
    int m;
    if (pkt_id != seen_id) begin
      seen_id = pkt_id;
      nbits = 0;
    end
    if (nbits < 128) begin
      cap_oe[nbits] = swdio_oe;
      cap_v[nbits]  = swdio_o;
    end
    if (nbits == 7) rnw_seen = cap_v[2];
    m = nbits + 1;
    tgt_oe = 1'b0;
    if (m >= 9 && m <= 11) begin
      tgt_oe = 1'b1;
      tgt_o  = tgt_ack[m-9];
    end else if (rnw_seen && tgt_ack == 3'b001 && m >= 12 && m <= 44) begin
      tgt_oe = 1'b1;
      tgt_o  = (m == 44) ? ((^tgt_rdata) ^ tgt_flip) : tgt_rdata[m-12];
    end
    nbits = nbits + 1;
  end

  always @(negedge clk) if (tgt_oe && swdio_oe) clash = clash + 1;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R11 watchdog: actual=no completion expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] host_bits(input int first, input int len);
    logic [63:0] v;
    v = '0;
    for (int i = 0; i < len; i++) v[i] = cap_v[first+i];
    return v;
  endfunction

  function automatic logic [7:0] hdr_msb_first();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[7-i] = cap_v[i];
    return v;
  endfunction

  function automatic int undriven(input int first, input int len);
    int c;
    c = 0;
    for (int i = first; i < first + len; i++) if (!cap_oe[i]) c++;
    return c;
  endfunction

  task automatic xfer(input logic ap, input logic rnw, input logic [1:0] a,
                      input logic [31:0] wd, input logic [7:0] d, output int cyc);
    @(negedge clk);
    div_half  = d;
    pkt_id    = pkt_id + 1;
    req_ap    = ap;
    req_rnw   = rnw;
    req_addr  = a;
    req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!rsp_valid && cyc < 40000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic test_reset();
    chk("R1 swclk", 64'(swclk), 64'd0);
    chk("R1 oe", 64'(swdio_oe), 64'd0);
    chk("R1 ready", 64'(req_ready), 64'd1);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
  endtask

  task automatic test_read_ok();
    int cyc;
    tgt_ack = 3'b001; tgt_rdata = 32'h2BA0_1477; tgt_flip = 1'b0;
    xfer(1'b0, 1'b1, 2'd0, 32'd0, 8'd1, cyc);
    chk("R2 header dp read", 64'(hdr_msb_first()), 64'hA5);
    chk("R4 trn after header", 64'(undriven(8, 1)), 64'd1);
    chk("R5 ack ok", 64'(rsp_ack), 64'b001);
    chk("R6 read word", 64'(rsp_rdata), 64'h2BA0_1477);
    chk("R6 parity ok", 64'(rsp_par_err), 64'd0);
    chk("R6 undriven ack+data+trn", 64'(undriven(9, 37)), 64'd37);
    chk("R10 idle bits low", 64'(host_bits(46, 2)), 64'd0);
    chk("R10 idle bits driven", 64'(undriven(46, 2)), 64'd0);
    chk("R11 bit count read", 64'(nbits), 64'd48);
    chk("R11 cycles read", 64'(cyc), 64'(2 * 48 * 2));
    chk("R10 line low after", 64'({swdio_oe, swdio_o}), 64'b10);
  endtask

  task automatic test_read_parity();
    int cyc;
    tgt_ack = 3'b001; tgt_rdata = 32'h0288_0000; tgt_flip = 1'b1;
    xfer(1'b1, 1'b1, 2'd3, 32'd0, 8'd0, cyc);
    chk("R2 header ap read a3", 64'(hdr_msb_first()), 64'hF9);
    chk("R6 word with bad parity", 64'(rsp_rdata), 64'h0288_0000);
    chk("R6 parity error", 64'(rsp_par_err), 64'd1);
    chk("R11 cycles div0", 64'(cyc), 64'(2 * 48 * 1));
    tgt_flip = 1'b0;
  endtask

  task automatic test_write_ok(input logic [31:0] wd, input logic par);
    int cyc;
    tgt_ack = 3'b001;
    xfer(1'b0, 1'b0, 2'd2, wd, 8'd0, cyc);
    chk("R2 header dp write", 64'(hdr_msb_first()), 64'h8D);
    chk("R4 trn before write data", 64'(undriven(12, 1)), 64'd1);
    chk("R7 write word", host_bits(13, 32), 64'(wd));
    chk("R7 write parity", 64'(cap_v[45]), 64'(par));
    chk("R7 data driven", 64'(undriven(13, 33)), 64'd0);
    chk("R5 ack ok write", 64'(rsp_ack), 64'b001);
    chk("R11 cycles write", 64'(cyc), 64'(2 * 48 * 1));
  endtask

  task automatic test_no_data(input logic [2:0] code, input logic rnw);
    int cyc;
    tgt_ack = code; tgt_rdata = 32'hFFFF_FFFF;
    xfer(1'b0, rnw, 2'd1, 32'h1234_5678, 8'd3, cyc);
    chk("R8 ack code", 64'(rsp_ack), 64'(code));
    chk("R8 rdata zero", 64'(rsp_rdata), 64'd0);
    chk("R8 no parity flag", 64'(rsp_par_err), 64'd0);
    chk("R8 bit count", 64'(nbits), 64'd15);
    chk("R8 single trn", 64'(undriven(12, 1)), 64'd1);
    chk("R10 idle after wait/fault", 64'({undriven(13, 2), host_bits(13, 2)}), 64'd0);
    chk("R11 cycles no data", 64'(cyc), 64'(2 * 15 * 4));
  endtask

  task automatic test_proto(input logic [2:0] code);
    int cyc;
    tgt_ack = code;
    xfer(1'b0, 1'b1, 2'd0, 32'd0, 8'd1, cyc);
    chk("R9 ack code", 64'(rsp_ack), 64'(code));
    chk("R9 line reset flag", 64'(rsp_line_reset), 64'd1);
    chk("R9 bit count", 64'(nbits), 64'd46);
    chk("R9 undriven backoff", 64'(undriven(12, 34)), 64'd34);
    chk("R9 left undriven", 64'(swdio_oe), 64'd0);
    chk("R11 cycles backoff", 64'(cyc), 64'(2 * 46 * 2));
  endtask

  task automatic test_clock_div();
    int cyc;
    longint t0, t1, t2;
    tgt_ack = 3'b010;
    fork
      xfer(1'b0, 1'b1, 2'd0, 32'd0, 8'd3, cyc);
      begin
        @(posedge swclk); t0 = $time;
        @(negedge swclk); t1 = $time;
        @(posedge swclk); t2 = $time;
      end
    join
    chk("R3 high half", 64'((t1 - t0) / CLK_PERIOD), 64'd4);
    chk("R3 low half", 64'((t2 - t1) / CLK_PERIOD), 64'd4);
    chk("R3 clock low after", 64'(swclk), 64'd0);
  endtask

  task automatic test_busy_ignore();
    int cyc;
    int rises;
    tgt_ack = 3'b001; tgt_rdata = 32'hCAFE_0001;
    fork
      xfer(1'b0, 1'b1, 2'd0, 32'd0, 8'd1, cyc);
      begin
        repeat (30) @(negedge clk);
        chk("R12 not ready while busy", 64'(req_ready), 64'd0);
        req_ap = 1'b1; req_rnw = 1'b0; req_addr = 2'd3;
        req_valid = 1'b1;
        repeat (10) @(negedge clk);
        req_valid = 1'b0;
      end
    join
    chk("R12 header unchanged", 64'(hdr_msb_first()), 64'hA5);
    chk("R12 read word unchanged", 64'(rsp_rdata), 64'hCAFE_0001);
    chk("R12 length unchanged", 64'(cyc), 64'(2 * 48 * 2));
    rises = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (swclk || !req_ready) rises++;
    end
    chk("R12 no second packet", 64'(rises), 64'd0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_read_ok();
    test_read_parity();
    test_write_ok(32'h0000_0007, 1'b1);
    test_write_ok(32'h5000_0000, 1'b0);
    test_no_data(3'b010, 1'b1);
    test_no_data(3'b100, 1'b0);
    test_proto(3'b111);
    test_proto(3'b000);
    test_clock_div();
    test_busy_ignore();
    chk("R4 no drive clash", 64'(clash), 64'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule